// File: doc/BRIEF.md
# Link Self-Test Pattern Checker

This block sits on the receive side of a serial display link, after clock recovery and deframing. Each received frame carries a payload word and two control bits. When the control bits mark a frame as self-test traffic, the block stops treating the payload as data. It checks each word against a pseudo-random sequence that it generates locally and counts every bit that differs.

While a test is in progress, the parallel output bus shows the running mismatch count instead of payload. A single pass output rises at the end of a fixed window of compared bits, but only if no mismatch was seen. It stays high until the link returns to normal frames. If the receiver reports loss of lock, the test is aborted and pass is held low.

A matching transmit-side pattern source is provided as a separate module so that the whole loop can be exercised.

Top module: `bist_link_checker`

## Requirements
- R1: A frame with valid high and control bits equal to 2'b11 (test), received while idle with lock-loss low, starts a test. The mismatch count reads zero on the bus one cycle later. That first word only seeds the local generator and is not compared.
- R2: The pattern generator is a 7-bit register s. Each step computes b = s[6] ^ s[5] and updates s to {s[5:0], b}. Bit i of a word is the b of the i-th step, with i = 0 first. Consecutive words continue the same sequence. The transmit source starts from its SEED parameter and moves one word forward per advance pulse.
- R3: During a test, every compared word adds the number of differing bits to the count. From the cycle after that frame, the bus shows the count zero-extended to the bus width.
- R4: The count saturates at 2^CNT_W-1 and never wraps.
- R5: The test window closes on the compared word that brings the total of compared bits to 2^WIN_LOG2 or more. Pass rises the cycle after that word only if the count is zero. Test words that arrive after the window has closed change neither the count nor pass.
- R6: Pass stays high until a valid frame with control bits other than 2'b11 arrives. One cycle after that frame, pass is low and the bus shows that frame's payload.
- R7: Lock-loss during a test, or after its window has closed, forces pass low from the next cycle. It freezes the count and ignores further test words until a normal frame arrives. Lock-loss high while idle prevents a test from starting.
- R8: Outside a test, the bus shows the payload of the last valid normal frame, and shows zero after reset. Pass is low after reset.
- R9: Frames with valid low have no effect on the count, the bus or the test progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered parallel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid_i | input | 1 | Frame present this cycle |
| frm_ctrl_i | input | 2 | Frame control bits, 2'b11 marks test traffic |
| frm_data_i | input | DATA_W | Frame payload word |
| lock_lost_i | input | 1 | Receiver has lost lock |
| bus_o | output | DATA_W | Payload outside a test, mismatch count during a test |
| pass_o | output | 1 | Test passed, held until normal frames return |

## Verification
The hardest situation to reach is the end of the window, because at full size it lies 2^30 bits away. The bench therefore shrinks WIN_LOG2 to 8, which gives eleven 24-bit compared words. It checks that pass is still low after the tenth word and high after the eleventh, and it places a corrupted word at different positions in the window, including the last one. Lowering CNT_W to 6 lets three fully inverted words drive the count into saturation. Lock-loss is applied both mid-window and after a passing window, so that both the abort path and the release of a held pass are exercised.

// File: rtl/bist_pkg.sv
package bist_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_RUN   = 2'd1,
        MODE_DONE  = 2'd2,
        MODE_ABORT = 2'd3
    } bist_mode_e;

    localparam logic [1:0] CTRL_TEST = 2'b11;
    localparam int         PRBS_LEN  = 7;
endpackage

// File: rtl/bist_prbs_word.sv
module bist_prbs_word #(
    parameter int DATA_W = 24
) (
    input  logic [bist_pkg::PRBS_LEN-1:0] state_i,
    output logic [DATA_W-1:0]             word_o,
    output logic [bist_pkg::PRBS_LEN-1:0] state_o
);
    // Unrolled serial LFSR, x^7 + x^6 + 1, one output bit per step
    always_comb begin
        logic [bist_pkg::PRBS_LEN-1:0] s;
        logic                          b;
        s      = state_i;
        word_o = '0;
        for (int i = 0; i < DATA_W; i++) begin
            b         = s[6] ^ s[5];
            word_o[i] = b;
            s         = {s[5:0], b};
        end
        state_o = s;
    end
endmodule

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen #(
    parameter int                           DATA_W = 24,
    parameter logic [bist_pkg::PRBS_LEN-1:0] SEED  = 7'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    output logic [DATA_W-1:0] word_o
);
    logic [bist_pkg::PRBS_LEN-1:0] lfsr_d, lfsr_q, lfsr_nxt;

    bist_prbs_word #(.DATA_W(DATA_W)) u_word (
        .state_i (lfsr_q),
        .word_o  (word_o),
        .state_o (lfsr_nxt)
    );

    always_comb begin
        lfsr_d = adv_i ? lfsr_nxt : lfsr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assert_gen_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/bist_err_accum.sv
module bist_err_accum #(
    parameter int CNT_W = 16,
    parameter int ADD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             add_en_i,
    input  logic [ADD_W-1:0] add_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int             SUM_W   = ((CNT_W > ADD_W) ? CNT_W : ADD_W) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = SUM_W'(cnt_q) + SUM_W'(add_i);
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (add_en_i)
            cnt_d = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clear_i) |=> cnt_q == CNT_MAX);
    assert_count_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/bist_window.sv
module bist_window #(
    parameter int DATA_W   = 24,
    parameter int WIN_LOG2 = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam int BITS_W = WIN_LOG2 + 1;

    logic [BITS_W-1:0] bits_d, bits_q, bits_nxt;

    always_comb begin
        bits_nxt = bits_q + BITS_W'(DATA_W);
        last_o   = step_i && bits_nxt[WIN_LOG2];
        bits_d   = bits_q;
        if (clear_i)     bits_d = '0;
        else if (last_o) bits_d = '0;
        else if (step_i) bits_d = bits_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bits_q[WIN_LOG2]);
endmodule

// File: rtl/bist_link_checker.sv
module bist_link_checker
    import bist_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int CNT_W    = 16,
    parameter int WIN_LOG2 = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid_i,
    input  logic [1:0]        frm_ctrl_i,
    input  logic [DATA_W-1:0] frm_data_i,
    input  logic              lock_lost_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              pass_o
);
    localparam int ADD_W = $clog2(DATA_W + 1);

    typedef struct packed {
        bist_mode_e          mode;
        logic [PRBS_LEN-1:0] lfsr;
        logic                pass;
        logic [DATA_W-1:0]   pay;
    } chk_state_t;

    chk_state_t          st_d, st_q;
    logic [DATA_W-1:0]   exp_word;
    logic [PRBS_LEN-1:0] exp_next, seed;
    logic [ADD_W-1:0]    nerr;
    logic [CNT_W-1:0]    cnt;
    logic                is_test, is_norm, entry, cmp, win_last;

    bist_prbs_word #(.DATA_W(DATA_W)) u_exp (
        .state_i (st_q.lfsr),
        .word_o  (exp_word),
        .state_o (exp_next)
    );

    bist_err_accum #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (entry),
        .add_en_i (cmp),
        .add_i    (nerr),
        .cnt_o    (cnt)
    );

    bist_window #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (entry),
        .step_i  (cmp),
        .last_o  (win_last)
    );

    always_comb begin
        is_test = frm_valid_i && (frm_ctrl_i == CTRL_TEST);
        is_norm = frm_valid_i && (frm_ctrl_i != CTRL_TEST);
        entry   = (st_q.mode == MODE_IDLE) && is_test && !lock_lost_i;
        cmp     = (st_q.mode == MODE_RUN) && is_test && !lock_lost_i;

        // Generator state that would have followed the received word
        for (int k = 0; k < PRBS_LEN; k++)
            seed[k] = frm_data_i[DATA_W-1-k];

        nerr = '0;
        for (int i = 0; i < DATA_W; i++)
            nerr = nerr + ADD_W'(frm_data_i[i] ^ exp_word[i]);

        st_d = st_q;
        if (is_norm) begin
            st_d.mode = MODE_IDLE;
            st_d.pay  = frm_data_i;
            st_d.pass = 1'b0;
        end else begin
            unique case (st_q.mode)
                MODE_IDLE: begin
                    if (entry) begin
                        st_d.mode = MODE_RUN;
                        st_d.lfsr = seed;
                        st_d.pass = 1'b0;
                    end
                end
                MODE_RUN: begin
                    if (lock_lost_i) begin
                        st_d.mode = MODE_ABORT;
                        st_d.pass = 1'b0;
                    end else if (cmp) begin
                        st_d.lfsr = exp_next;
                        if (win_last) begin
                            st_d.mode = MODE_DONE;
                            st_d.pass = (cnt == '0) && (nerr == '0);
                        end
                    end
                end
                MODE_DONE: begin
                    if (lock_lost_i) begin
                        st_d.mode = MODE_ABORT;
                        st_d.pass = 1'b0;
                    end
                end
                MODE_ABORT: st_d.pass = 1'b0;
                default:    st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_IDLE;
            st_q.lfsr <= '0;
            st_q.pass <= 1'b0;
            st_q.pay  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_o  = (st_q.mode == MODE_IDLE) ? st_q.pay : DATA_W'(cnt);
    assign pass_o = st_q.pass;

    assert_entry_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (cnt == '0 && st_q.mode == MODE_RUN));
    assert_pass_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> cnt == '0);
    assert_pass_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o && !is_norm && !lock_lost_i) |=> pass_o);
    assert_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_norm |=> (st_q.mode == MODE_IDLE && !pass_o));
    assert_lock_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != MODE_IDLE && lock_lost_i && !is_norm) |=>
        (!pass_o && st_q.mode == MODE_ABORT));
    assert_idle_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_valid_i && !lock_lost_i) |=> ($stable(cnt) && $stable(st_q.mode)));
endmodule

// File: tb/sim_bist_link_checker.sv
`timescale 1ns/100ps
module sim_bist_link_checker;
    localparam int DATA_W    = 24;
    localparam int CNT_W     = 6;
    localparam int WIN_LOG2  = 8;
    localparam int WIN_WORDS = ((1 << WIN_LOG2) + DATA_W - 1) / DATA_W;
    localparam logic [6:0] GEN_SEED = 7'h25;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frm_valid = 1'b0, lock_lost = 1'b0, gen_adv = 1'b0;
    logic [1:0] frm_ctrl = 2'b00;
    logic [DATA_W-1:0] frm_data = '0, bus, gen_word;
    logic pass;
    int checks = 0, errors = 0;
    logic [6:0] tx_s;

    always #2.5 clk = ~clk;

    bist_link_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WIN_LOG2(WIN_LOG2)) u0 (
        .clk(clk), .rst_n(rst_n), .frm_valid_i(frm_valid), .frm_ctrl_i(frm_ctrl),
        .frm_data_i(frm_data), .lock_lost_i(lock_lost), .bus_o(bus), .pass_o(pass));

    bist_pattern_gen #(.DATA_W(DATA_W), .SEED(GEN_SEED)) u_gen (
        .clk(clk), .rst_n(rst_n), .adv_i(gen_adv), .word_o(gen_word));

    // Model of the R2 sequence
    function automatic logic [DATA_W-1:0] m_word(input logic [6:0] s0);
        logic [6:0] s = s0;
        logic b;
        for (int i = 0; i < DATA_W; i++) begin
            b = s[6] ^ s[5];
            m_word[i] = b;
            s = {s[5:0], b};
        end
    endfunction

    function automatic logic [6:0] m_adv(input logic [6:0] s0);
        logic [6:0] s = s0;
        for (int i = 0; i < DATA_W; i++) s = {s[5:0], s[6] ^ s[5]};
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] m_mask(input int n);
        m_mask = '0;
        for (int i = 0; i < n; i++) m_mask[i] = 1'b1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic v, input logic [1:0] c, input logic [DATA_W-1:0] d,
                        input logic l);
        frm_valid = v; frm_ctrl = c; frm_data = d; lock_lost = l;
        @(posedge clk);
        @(negedge clk);
        frm_valid = 1'b0; lock_lost = 1'b0;
    endtask

    task automatic tx_test(input logic [DATA_W-1:0] flip);
        logic [DATA_W-1:0] w = m_word(tx_s);
        tx_s = m_adv(tx_s);
        send(1'b1, 2'b11, w ^ flip, 1'b0);
    endtask

    // seed, corrupted word index, flipped bits, expected count, expected pass
    localparam int NV = 4;
    localparam logic [22:0] VEC [NV] = '{
        {7'h01, 4'd3,  5'd0,  6'd0,  1'b1},
        {7'h5A, 4'd0,  5'd1,  6'd1,  1'b0},
        {7'h7F, 4'd10, 5'd5,  6'd5,  1'b0},
        {7'h33, 4'd6,  5'd24, 6'd24, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset bus", 32'(bus), 0);
        chk("R8 reset pass", 32'(pass), 0);
        chk("R2 gen first word", 32'(gen_word), 32'(m_word(GEN_SEED)));
        gen_adv = 1'b1; @(negedge clk); gen_adv = 1'b0;
        chk("R2 gen second word", 32'(gen_word), 32'(m_word(m_adv(GEN_SEED))));

        for (int v = 0; v < NV; v++) begin
            logic [22:0] e = VEC[v];
            send(1'b1, 2'b00, 24'hABC000 | 24'(v), 1'b0);
            chk("R8 normal payload", 32'(bus), 32'(24'hABC000 | 24'(v)));
            tx_s = e[22:16];
            tx_test('0);
            chk("R1 count after entry", 32'(bus), 0);
            for (int i = 0; i < WIN_WORDS; i++) begin
                tx_test((i == int'(e[15:12])) ? m_mask(int'(e[11:7])) : '0);
                if (i == WIN_WORDS - 2) chk("R5 pass before window end", 32'(pass), 0);
            end
            chk("R3 error count", 32'(bus), 32'(e[6:1]));
            chk("R5 pass at window end", 32'(pass), 32'(e[0]));
            tx_test(m_mask(3));
            chk("R5 late word ignored count", 32'(bus), 32'(e[6:1]));
            chk("R6 pass held", 32'(pass), 32'(e[0]));
            send(1'b1, 2'b01, 24'h0F0F0F, 1'b0);
            chk("R6 exit pass low", 32'(pass), 0);
            chk("R6 exit payload", 32'(bus), 32'h0F0F0F);
        end

        // R9: invalid frame does not start a test
        send(1'b1, 2'b00, 24'h123456, 1'b0);
        send(1'b0, 2'b11, 24'hFFFFFF, 1'b0);
        chk("R9 invalid frame ignored", 32'(bus), 32'h123456);

        // R4: saturation
        tx_s = 7'h11;
        tx_test('0);
        tx_test('1);
        chk("R4 count 24", 32'(bus), 24);
        tx_test('1);
        chk("R4 count 48", 32'(bus), 48);
        tx_test('1);
        chk("R4 saturated", 32'(bus), 63);
        tx_test('1);
        chk("R4 stays saturated", 32'(bus), 63);
        send(1'b1, 2'b00, 24'h000111, 1'b0);
        // R1: re-entry clears count
        tx_s = 7'h22;
        tx_test('0);
        chk("R1 reentry clears count", 32'(bus), 0);

        // R7: abort mid-window
        tx_test(m_mask(2));
        tx_test('0);
        send(1'b0, 2'b00, '0, 1'b1);
        chk("R7 abort pass low", 32'(pass), 0);
        for (int i = 0; i < WIN_WORDS; i++) tx_test(m_mask(1));
        chk("R7 count frozen", 32'(bus), 2);
        chk("R7 no pass after abort", 32'(pass), 0);
        send(1'b1, 2'b00, 24'h00AA00, 1'b0);
        // R7: lock blocks entry while idle
        send(1'b1, 2'b11, 24'h555555, 1'b1);
        chk("R7 lock blocks entry", 32'(bus), 32'h00AA00);

        // R9 gaps mid-run, then R7 lock after pass
        tx_s = 7'h6B;
        tx_test('0);
        for (int i = 0; i < WIN_WORDS; i++) begin
            tx_test('0);
            if (i == 4) send(1'b0, 2'b11, 24'hFFFFFF, 1'b0);
        end
        chk("R9 gaps keep pass", 32'(pass), 1);
        send(1'b0, 2'b00, '0, 1'b1);
        chk("R7 lock clears held pass", 32'(pass), 0);
        send(1'b1, 2'b10, 24'h0000C3, 1'b0);
        chk("R6 exit after abort", 32'(bus), 32'h0000C3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule